// File: doc/BRIEF.md
# Asynchronous Serial Channel

This block is one full-duplex asynchronous serial channel. A character written into its transmit holding register is framed and shifted out on `txd`: a low start bit, then 7, 8 or 9 data bits with the least significant bit first, then an optional parity bit and one or two high stop bits. The receiver watches `rxd` and rebuilds characters in the same format. It places each one in a single receive buffer and flags overrun, framing and parity faults, along with their logical OR.

Both directions share one bit-clock generator that runs at 16 ticks per bit. It draws its source pulses from one of several places: the system clock directly, the system clock divided by 8 or by 32, an auxiliary enable input, or rising edges on an external clock pin. An 8-bit divider then takes every (n+1)-th source pulse. The transmit interrupt fires either when the holding register is emptied or when the line goes idle after the last frame, depending on a mode input. A second interrupt marks each stored received character.

Top module: `uart_async_chan`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `txd` is 1, `tx_buf_empty` is 1, and `rx_full`, `tx_irq`, `rx_irq` and all four error outputs are 0.
- R2: Each `char_len` value sets the data width of both directions: 0 gives 7 bits, 1 or 3 gives 8 bits, 2 gives 9 bits. A received character appears on `rx_data` with the unused upper bits at zero. `rx_full` is set and `rx_irq` pulses for one cycle.
- R3: A transmitted frame is made of one 0 start bit, the data least significant bit first, a parity bit when `par_en` is 1, and then one stop bit at 1 (two when `stop2` is 1). Each bit lasts 16 ticks, and `txd` rests at 1 between frames.
- R4: When `ext_sel` is 0, one bit lasts 16·(`brg_n`+1)·D clock cycles. D is 1, 8 or 32 for `clk_src` 0, 1 or 2. When `clk_src` is 3, each cycle with `aux_en` high counts as one source pulse.
- R5: When `ext_sel` is 1, each rising edge of `ext_clk` is one source pulse. One bit then lasts 16·(`brg_n`+1) such edges.
- R6: A falling edge on `rxd` starts reception only if `rxd` is still low 8 ticks later. A shorter low pulse yields no character and no interrupt.
- R7: If the first stop bit is sampled low, `err_frame` is set together with the stored character. The data is still delivered. A second stop bit is not checked.
- R8: With `par_en`=1, the data bits plus the parity bit hold an even number of ones when `par_odd`=0, or an odd number when `par_odd`=1. A received mismatch sets `err_parity` together with the stored character.
- R9: If a character completes while `rx_full` is 1 and `rx_rd` is 0, `err_overrun` is set, `rx_data` keeps the earlier character, and `rx_irq` does not pulse.
- R10: `err_sum` is the OR of the three error flags. The flags hold until a cycle with `rx_rd` (which also clears `rx_full`) or with `err_clr` (which leaves `rx_full` unchanged).
- R11: With `tx_irq_done`=0, `tx_irq` pulses once when the holding register moves into the shifter. With `tx_irq_done`=1, it pulses once when the last stop bit ends and no character is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_src | input | 2 | Internal source: 0 clk, 1 clk/8, 2 clk/32, 3 aux_en pulses |
| ext_sel | input | 1 | 1: source pulses are rising edges of ext_clk |
| ext_clk | input | 1 | External clock pin (asynchronous) |
| aux_en | input | 1 | Auxiliary source pulse |
| brg_n | input | 8 | Divider value n |
| char_len | input | 2 | Data length code (R2) |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 odd parity, 0 even |
| stop2 | input | 1 | Two stop bits on transmit |
| tx_irq_done | input | 1 | Transmit interrupt on completion instead of buffer empty |
| tx_wr | input | 1 | Write tx_data into the holding register |
| tx_data | input | 9 | Character to send |
| tx_buf_empty | output | 1 | Holding register free |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input (asynchronous) |
| rx_rd | input | 1 | Read strobe: frees buffer, clears flags |
| err_clr | input | 1 | Clears the error flags |
| rx_data | output | 9 | Received character |
| rx_full | output | 1 | Receive buffer holds an unread character |
| rx_irq | output | 1 | One-cycle pulse per stored character |
| tx_irq | output | 1 | One-cycle transmit interrupt pulse |
| err_overrun | output | 1 | Overrun flag |
| err_frame | output | 1 | Framing error flag |
| err_parity | output | 1 | Parity error flag |
| err_sum | output | 1 | OR of the three error flags |

## Verification
The assertions watch the interrupt outputs and the receive flags every cycle. Each interrupt must stay a single-cycle pulse. A stored character must always come with `rx_full`. A framing flag may only rise together with a stored character. A read or a clear must empty the flags on the next cycle, and an overrun must leave the buffer untouched. The bench scenarios are the only way to show the behaviour that depends on sequences and timing: the exact bit order and parity value on `txd`, the bit period for every clock source and divider value, rejection of a short start glitch, the delivery of faulty frames with the right flag, and the point inside a frame where each transmit interrupt mode fires.

// File: rtl/uart_chan_pkg.sv
package uart_chan_pkg;
  localparam int DATA_MAX = 9;

  typedef enum logic [1:0] {
    SRC_DIV1  = 2'd0,
    SRC_DIV8  = 2'd1,
    SRC_DIV32 = 2'd2,
    SRC_AUX   = 2'd3
  } clk_src_e;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_BITS
  } rx_state_e;

  // Number of data bits for a length code; code 3 falls back to 8.
  function automatic logic [3:0] data_bits(input logic [1:0] code);
    case (code)
      2'd0:    data_bits = 4'd7;
      2'd2:    data_bits = 4'd9;
      default: data_bits = 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
  import uart_chan_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int PRE_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       src_sel,
  input  logic             use_ext,
  input  logic             ext_clk,
  input  logic             aux_en,
  input  logic [DIV_W-1:0] div_n,
  output logic             tick
);
  logic [PRE_W-1:0] pre;
  logic [2:0]       ext_sync;
  logic [DIV_W-1:0] cnt;
  logic             src_en, ext_rise, pulse;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre      <= '0;
      ext_sync <= '0;
    end else begin
      pre      <= pre + 1'b1;
      ext_sync <= {ext_sync[1:0], ext_clk};
    end
  end

  assign ext_rise = ext_sync[1] & ~ext_sync[2];

  always_comb begin
    case (clk_src_e'(src_sel))
      SRC_DIV1:  src_en = 1'b1;
      SRC_DIV8:  src_en = (pre[2:0] == 3'd7);
      SRC_DIV32: src_en = (pre == '1);
      default:   src_en = aux_en;
    endcase
  end

  assign pulse = use_ext ? ext_rise : src_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (pulse) begin
        if (cnt >= div_n) begin
          cnt  <= '0;
          tick <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/uart_tx.sv
module uart_tx
  import uart_chan_pkg::*;
#(
  parameter int DW = DATA_MAX,
  localparam int FW = DW + 4,
  localparam int LW = $clog2(FW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [1:0]    len,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          stop2,
  input  logic          irq_on_done,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic          txd,
  output logic          irq,
  output logic          buf_empty
);
  logic [DW-1:0] hold, dmask;
  logic          hold_full, busy, pbit;
  logic [FW-1:0] sh, frame;
  logic [LW-1:0] left, nbits;
  logic [3:0]    tc, nb;

  always_comb begin
    nb    = data_bits(len);
    dmask = '0;
    for (int i = 0; i < DW; i++)
      if (i < int'(nb)) dmask[i] = hold[i];
    pbit  = (^dmask) ^ par_odd;
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DW; i++)
      if (i < int'(nb)) frame[i+1] = hold[i];
    if (par_en) frame[int'(nb) + 1] = pbit;
    nbits = LW'(nb) + LW'(2) + LW'(par_en) + LW'(stop2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold      <= '0;
      hold_full <= 1'b0;
      sh        <= '1;
      left      <= '0;
      busy      <= 1'b0;
      tc        <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (wr) begin
        hold      <= wdata;
        hold_full <= 1'b1;
      end
      if (!busy && hold_full) begin
        sh   <= frame;
        left <= nbits;
        busy <= 1'b1;
        tc   <= '0;
        if (!wr) hold_full <= 1'b0;
        if (!irq_on_done) irq <= 1'b1;
      end else if (busy && tick) begin
        tc <= tc + 1'b1;
        if (tc == 4'd15) begin
          sh   <= {1'b1, sh[FW-1:1]};
          left <= left - 1'b1;
          if (left == LW'(1)) begin
            busy <= 1'b0;
            if (irq_on_done && !hold_full) irq <= 1'b1;
          end
        end
      end
    end
  end

  assign txd       = sh[0];
  assign buf_empty = ~hold_full;
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_chan_pkg::*;
#(
  parameter int DW = DATA_MAX
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [1:0]    len,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          rxd,
  input  logic          rd,
  input  logic          clr,
  output logic [DW-1:0] data,
  output logic          full,
  output logic          oe,
  output logic          fe,
  output logic          pe,
  output logic          irq
);
  logic [2:0]    rs;
  logic          line, line_prev, pbit, pe_new;
  rx_state_e     st;
  logic [3:0]    tc, idx, nb, stop_idx;
  logic [DW-1:0] sh;

  assign line      = rs[1];
  assign line_prev = rs[2];
  assign nb        = data_bits(len);
  assign stop_idx  = nb + {3'b000, par_en};
  assign pe_new    = par_en & ((^sh) ^ pbit ^ par_odd);

  always_ff @(posedge clk) begin
    if (rst) begin
      rs   <= '1;
      st   <= RX_IDLE;
      tc   <= '0;
      idx  <= '0;
      sh   <= '0;
      pbit <= 1'b0;
      data <= '0;
      full <= 1'b0;
      oe   <= 1'b0;
      fe   <= 1'b0;
      pe   <= 1'b0;
      irq  <= 1'b0;
    end else begin
      rs  <= {rs[1:0], rxd};
      irq <= 1'b0;
      if (rd) begin
        full <= 1'b0;
        oe   <= 1'b0;
        fe   <= 1'b0;
        pe   <= 1'b0;
      end
      if (clr) begin
        oe <= 1'b0;
        fe <= 1'b0;
        pe <= 1'b0;
      end
      case (st)
        RX_IDLE: begin
          if (line_prev && !line) begin
            st <= RX_START;
            tc <= '0;
          end
        end
        RX_START: begin
          if (tick) begin
            tc <= tc + 1'b1;
            if (tc == 4'd7) begin
              if (line) st <= RX_IDLE;
              else begin
                st  <= RX_BITS;
                idx <= '0;
                sh  <= '0;
              end
            end
          end
        end
        default: begin
          if (tick) begin
            tc <= tc + 1'b1;
            if (tc == 4'd7) begin
              idx <= idx + 1'b1;
              if (idx < nb) sh[idx] <= line;
              else if (idx != stop_idx) pbit <= line;
              else begin
                st <= RX_IDLE;
                if (!full || rd) begin
                  data <= sh;
                  full <= 1'b1;
                  fe   <= ~line;
                  pe   <= pe_new;
                  oe   <= 1'b0;
                  irq  <= 1'b1;
                end else begin
                  oe <= 1'b1;
                end
              end
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/uart_async_chan.sv
module uart_async_chan
  import uart_chan_pkg::*;
#(
  parameter int DW    = DATA_MAX,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       clk_src,
  input  logic             ext_sel,
  input  logic             ext_clk,
  input  logic             aux_en,
  input  logic [DIV_W-1:0] brg_n,
  input  logic [1:0]       char_len,
  input  logic             par_en,
  input  logic             par_odd,
  input  logic             stop2,
  input  logic             tx_irq_done,
  input  logic             tx_wr,
  input  logic [DW-1:0]    tx_data,
  output logic             tx_buf_empty,
  output logic             txd,
  input  logic             rxd,
  input  logic             rx_rd,
  input  logic             err_clr,
  output logic [DW-1:0]    rx_data,
  output logic             rx_full,
  output logic             rx_irq,
  output logic             tx_irq,
  output logic             err_overrun,
  output logic             err_frame,
  output logic             err_parity,
  output logic             err_sum
);
  logic tick;

  uart_baud_gen #(.DIV_W(DIV_W)) u_bgen (
    .clk(clk), .rst(rst), .src_sel(clk_src), .use_ext(ext_sel),
    .ext_clk(ext_clk), .aux_en(aux_en), .div_n(brg_n), .tick(tick)
  );

  uart_tx #(.DW(DW)) u_tx (
    .clk(clk), .rst(rst), .tick(tick), .len(char_len), .par_en(par_en),
    .par_odd(par_odd), .stop2(stop2), .irq_on_done(tx_irq_done),
    .wr(tx_wr), .wdata(tx_data), .txd(txd), .irq(tx_irq),
    .buf_empty(tx_buf_empty)
  );

  uart_rx #(.DW(DW)) u_rx (
    .clk(clk), .rst(rst), .tick(tick), .len(char_len), .par_en(par_en),
    .par_odd(par_odd), .rxd(rxd), .rd(rx_rd), .clr(err_clr),
    .data(rx_data), .full(rx_full), .oe(err_overrun), .fe(err_frame),
    .pe(err_parity), .irq(rx_irq)
  );

  assign err_sum = err_overrun | err_frame | err_parity;
endmodule

// File: rtl/uart_async_chan_chk.sv
module uart_async_chan_chk #(
  parameter int DW = 9
) (
  input logic          clk,
  input logic          rst,
  input logic          txd,
  input logic          tx_irq,
  input logic          rx_irq,
  input logic          rx_full,
  input logic          rx_rd,
  input logic          err_clr,
  input logic          err_overrun,
  input logic          err_frame,
  input logic          err_parity,
  input logic [DW-1:0] rx_data
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (txd && !rx_full && !tx_irq && !rx_irq));

  assert_rx_irq_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    rx_irq |=> !rx_irq);

  assert_rx_irq_full_R2: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> rx_full);

  assert_frame_with_char_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(err_frame) |-> rx_irq);

  assert_overrun_keeps_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(err_overrun) |-> ($stable(rx_data) && !rx_irq));

  assert_read_clears_R10: assert property (@(posedge clk) disable iff (rst)
    rx_rd |=> (rx_irq || (!rx_full && !err_frame && !err_parity && !err_overrun)));

  assert_clear_flags_R10: assert property (@(posedge clk) disable iff (rst)
    err_clr |=> (rx_irq || (!err_frame && !err_parity)));

  assert_tx_irq_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    tx_irq |=> !tx_irq);
endmodule

bind uart_async_chan uart_async_chan_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .txd(txd), .tx_irq(tx_irq), .rx_irq(rx_irq),
  .rx_full(rx_full), .rx_rd(rx_rd), .err_clr(err_clr),
  .err_overrun(err_overrun), .err_frame(err_frame),
  .err_parity(err_parity), .rx_data(rx_data)
);

// File: tb/tb_uart_async_chan.sv
module tb_uart_async_chan;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [8:0] data;
    logic       fe;
    logic       pe;
  } exp_t;

  logic clk = 0, rst = 1;
  logic [1:0] clk_src = 0, char_len = 1;
  logic ext_sel = 0, ext_clk = 0, aux_en = 0;
  logic [7:0] brg_n = 0;
  logic par_en = 0, par_odd = 0, stop2 = 0, tx_irq_done = 0;
  logic tx_wr = 0, rxd_bb = 1, loop = 1, rx_rd_mon = 0, rx_rd_man = 0, err_clr = 0;
  logic [8:0] tx_data = 0;
  logic tx_buf_empty, txd, rx_full, rx_irq, tx_irq;
  logic err_overrun, err_frame, err_parity, err_sum;
  logic [8:0] rx_data;
  logic rxd, rx_rd;
  logic [2:0] ext_div = 0;
  logic [1:0] aux_cnt = 0;

  int errors = 0, checks = 0, tx_irq_cnt = 0, bit_clk = 16;
  bit auto_rd = 1;
  exp_t exp_q[$];

  assign rxd   = loop ? txd : rxd_bb;
  assign rx_rd = rx_rd_mon | rx_rd_man;

  uart_async_chan dut (
    .clk(clk), .rst(rst), .clk_src(clk_src), .ext_sel(ext_sel),
    .ext_clk(ext_clk), .aux_en(aux_en), .brg_n(brg_n), .char_len(char_len),
    .par_en(par_en), .par_odd(par_odd), .stop2(stop2),
    .tx_irq_done(tx_irq_done), .tx_wr(tx_wr), .tx_data(tx_data),
    .tx_buf_empty(tx_buf_empty), .txd(txd), .rxd(rxd), .rx_rd(rx_rd),
    .err_clr(err_clr), .rx_data(rx_data), .rx_full(rx_full),
    .rx_irq(rx_irq), .tx_irq(tx_irq), .err_overrun(err_overrun),
    .err_frame(err_frame), .err_parity(err_parity), .err_sum(err_sum)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    ext_div <= ext_div + 1'b1;
    ext_clk <= ext_div[2];
    aux_cnt <= (aux_cnt == 2'd2) ? 2'd0 : aux_cnt + 1'b1;
    aux_en  <= (aux_cnt == 2'd2);
    if (!rst && tx_irq) tx_irq_cnt <= tx_irq_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Scoreboard monitor: every stored character is compared to the queue head.
  always @(negedge clk) begin
    rx_rd_mon <= 1'b0;
    if (!rst && rx_irq) begin
      if (exp_q.size() == 0) begin
        check(0, "R2", "unexpected character", int'(rx_data), 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(rx_data == e.data, "R2", "rx_data", int'(rx_data), int'(e.data));
        check(err_frame == e.fe, "R7", "err_frame", int'(err_frame), int'(e.fe));
        check(err_parity == e.pe, "R8", "err_parity", int'(err_parity), int'(e.pe));
        check(err_sum == (e.fe | e.pe), "R10", "err_sum", int'(err_sum), int'(e.fe | e.pe));
      end
      if (auto_rd) rx_rd_mon <= 1'b1;
    end
  end

  function automatic int nbits_of(input logic [1:0] l);
    return (l == 2'd0) ? 7 : (l == 2'd2) ? 9 : 8;
  endfunction

  function automatic logic [8:0] mask_of(input logic [8:0] d, input logic [1:0] l);
    return d & 9'((1 << nbits_of(l)) - 1);
  endfunction

  task automatic push_exp(input logic [8:0] d, input logic fe, input logic pe);
    exp_t e;
    e.data = mask_of(d, char_len);
    e.fe = fe;
    e.pe = pe;
    exp_q.push_back(e);
  endtask

  task automatic cfg(input logic [1:0] l, input logic pen, input logic podd,
                     input logic s2, input logic [1:0] src, input logic [7:0] n,
                     input int div);
    @(negedge clk);
    char_len = l; par_en = pen; par_odd = podd; stop2 = s2;
    clk_src = src; brg_n = n;
    bit_clk = 16 * (int'(n) + 1) * div;
  endtask

  task automatic send_tx(input logic [8:0] d, input bit expect_rx);
    while (!tx_buf_empty) @(negedge clk);
    tx_data = d;
    tx_wr = 1;
    if (expect_rx) push_exp(d, 0, 0);
    @(negedge clk);
    tx_wr = 0;
  endtask

  task automatic drain();
    int guard = 0;
    while (exp_q.size() != 0 && guard < 40000) begin
      @(negedge clk);
      guard++;
    end
    repeat (3 * bit_clk) @(negedge clk);
  endtask

  task automatic bb_bit(input logic v);
    rxd_bb = v;
    repeat (bit_clk) @(negedge clk);
  endtask

  // Bench-driven frame on rxd, with optional faults.
  task automatic bb_frame(input logic [8:0] d, input logic stop_v, input bit bad_par);
    logic [8:0] m;
    m = mask_of(d, char_len);
    bb_bit(1'b0);
    for (int i = 0; i < nbits_of(char_len); i++) bb_bit(m[i]);
    if (par_en) bb_bit((^m) ^ par_odd ^ bad_par);
    bb_bit(stop_v);
    bb_bit(1'b1);
    bb_bit(1'b1);
  endtask

  task automatic measure_bit(input string req, input int expv);
    time t0;
    send_tx(9'h055, 1);
    @(negedge txd);
    @(posedge txd);
    t0 = $time;
    @(negedge txd);
    check(($time - t0) / CLK_PERIOD == expv, req, "bit period",
          int'(($time - t0) / CLK_PERIOD), expv);
    drain();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int base;
    logic [10:0] cap, want;
    logic [6:0] d7;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(txd == 1 && tx_buf_empty == 1, "R1", "tx idle", int'({txd, tx_buf_empty}), 3);
    check(!rx_full && !rx_irq && !tx_irq, "R1", "rx/irq idle",
          int'({rx_full, rx_irq, tx_irq}), 0);
    check({err_overrun, err_frame, err_parity, err_sum} == 0, "R1", "flags",
          int'({err_overrun, err_frame, err_parity, err_sum}), 0);
    rst = 0;
    @(negedge clk);
    check(txd == 1 && !rx_full, "R1", "after reset", int'({txd, rx_full}), 2);

    // R2: loopback, back-to-back characters, several widths and formats
    cfg(2'd1, 0, 0, 0, 2'd0, 8'd0, 1);
    send_tx(9'h000, 1); send_tx(9'h0A5, 1); send_tx(9'h0FF, 1); send_tx(9'h13C, 1);
    drain();
    cfg(2'd0, 1, 0, 0, 2'd0, 8'd0, 1);
    send_tx(9'h1F5, 1); send_tx(9'h02A, 1);
    drain();
    cfg(2'd2, 1, 1, 1, 2'd0, 8'd0, 1);
    send_tx(9'h1A3, 1); send_tx(9'h055, 1); send_tx(9'h100, 1);
    drain();

    // R3: bit order and parity on txd, 7 bits odd parity two stops
    cfg(2'd0, 1, 1, 1, 2'd0, 8'd0, 1);
    d7 = 7'h35;
    want = {1'b1, 1'b1, ~^d7, d7, 1'b0};
    send_tx({2'b00, d7}, 1);
    @(negedge txd);
    repeat (8) @(negedge clk);
    for (int i = 0; i < 11; i++) begin
      cap[i] = txd;
      repeat (16) @(negedge clk);
    end
    check(cap == want, "R3", "txd frame bits", int'(cap), int'(want));
    check(txd == 1, "R3", "idle after frame", int'(txd), 1);
    drain();

    // R4: internal source rates; R5: external pin
    cfg(2'd1, 0, 0, 0, 2'd1, 8'd1, 8);  measure_bit("R4", 256);
    cfg(2'd1, 0, 0, 0, 2'd2, 8'd0, 32); measure_bit("R4", 512);
    cfg(2'd1, 0, 0, 0, 2'd3, 8'd1, 3);  measure_bit("R4", 96);
    cfg(2'd1, 0, 0, 0, 2'd0, 8'd2, 8);
    ext_sel = 1;
    measure_bit("R5", 384);
    ext_sel = 0;

    // R11: transmit interrupt modes
    cfg(2'd1, 0, 0, 0, 2'd0, 8'd0, 1);
    tx_irq_done = 0;
    base = tx_irq_cnt;
    send_tx(9'h011, 1);
    repeat (3) @(negedge clk);
    check(tx_irq_cnt - base == 1, "R11", "empty irq early", tx_irq_cnt - base, 1);
    repeat (200) @(negedge clk);
    check(tx_irq_cnt - base == 1, "R11", "empty irq once", tx_irq_cnt - base, 1);
    drain();
    tx_irq_done = 1;
    base = tx_irq_cnt;
    send_tx(9'h022, 1);
    repeat (100) @(negedge clk);
    check(tx_irq_cnt - base == 0, "R11", "done irq not mid-frame", tx_irq_cnt - base, 0);
    repeat (100) @(negedge clk);
    check(tx_irq_cnt - base == 1, "R11", "done irq after frame", tx_irq_cnt - base, 1);
    drain();
    tx_irq_done = 0;

    // R6: short start glitch rejected, then a valid frame
    loop = 0;
    rxd_bb = 0;
    repeat (5) @(negedge clk);
    rxd_bb = 1;
    repeat (300) @(negedge clk);
    check(!rx_full, "R6", "glitch produced character", int'(rx_full), 0);
    push_exp(9'h05A, 0, 0);
    bb_frame(9'h05A, 1, 0);
    drain();

    // R7: stop bit low; R10: flags cleared by read
    push_exp(9'h081, 1, 0);
    bb_frame(9'h081, 0, 0);
    drain();
    check(!err_frame && !err_sum && !rx_full, "R10", "read clears flags",
          int'({err_frame, err_sum, rx_full}), 0);

    // R8: even parity mismatch, then a good odd-parity frame
    cfg(2'd1, 1, 0, 0, 2'd0, 8'd0, 1);
    push_exp(9'h003, 0, 1);
    bb_frame(9'h003, 1, 1);
    cfg(2'd1, 1, 1, 0, 2'd0, 8'd0, 1);
    push_exp(9'h0C4, 0, 0);
    bb_frame(9'h0C4, 1, 0);
    drain();

    // R9: overrun keeps first character; R10: err_clr keeps buffer
    cfg(2'd1, 0, 0, 0, 2'd0, 8'd0, 1);
    auto_rd = 0;
    push_exp(9'h011, 0, 0);
    bb_frame(9'h011, 1, 0);
    bb_frame(9'h022, 1, 0);
    check(err_overrun && err_sum, "R9", "overrun flag", int'({err_overrun, err_sum}), 3);
    check(rx_data == 9'h011, "R9", "buffer kept", int'(rx_data), 'h11);
    err_clr = 1;
    @(negedge clk);
    err_clr = 0;
    @(negedge clk);
    check(!err_overrun && !err_sum && rx_full, "R10", "err_clr effect",
          int'({err_overrun, err_sum, rx_full}), 1);
    rx_rd_man = 1;
    @(negedge clk);
    rx_rd_man = 0;
    @(negedge clk);
    check(!rx_full, "R10", "read frees buffer", int'(rx_full), 0);
    auto_rd = 1;
    check(exp_q.size() == 0, "R2", "queue drained", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule